// File: doc/BRIEF.md
# Thermal-Latched Output Control Register

This block holds the configuration and status word for a four-channel output stage. It takes write frames that the serial front end has already decoded: a strobe, an address and a twelve-bit data field. From these it drives the power-up enable of each channel, the termination mode of outputs that are switched off, a global power-down indication and an active-low over-temperature alarm. It also returns the register's current value for readback.

A write to the control address is not applied when it arrives. It is parked in a pending register and becomes active on the next completed write frame, whatever that frame's address is. A raw over-temperature flag is synchronised and sets a sticky shutdown bit. That bit disconnects every channel and pulls the alarm low. It stays set after the temperature drops, until the host commits a control word that carries a zero in the status position.

Top module: `thermctl_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, ch_en is 0, hiz_sel is 0, pwr_down is 1, alarm_n is 1 and ctl_rdata is 0.
- R2: A write frame to address 7 changes no output in the clock edge that accepts it; its value is only held as pending.
- R3: The next write frame to any address 0..7 copies the pending value to the active configuration in the edge that accepts that frame. If that frame is itself a control write, it then becomes the new pending value. A frame that arrives with nothing pending leaves every output unchanged.
- R4: With no shutdown, ch_en[i] equals active data bit 2+i (channels A..D on bits 2..5), and hiz_sel equals active data bit 6 (1 = high impedance, 0 = resistor to ground).
- R5: pwr_down is 1 exactly when active bits 5:2 are all zero or the shutdown bit is set, and it is 0 whenever any ch_en bit is 1.
- R6: If over_temp is held high, alarm_n goes to 0 and ctl_rdata[0] goes to 1 on the third rising clock edge after over_temp rises, with two synchroniser stages. Both stay there after over_temp falls.
- R7: While the shutdown bit is set, ch_en is all zero and pwr_down is 1, whatever the enable bits hold. ctl_rdata[6:2] keeps reporting the stored enables and mode.
- R8: The shutdown bit clears only in the edge where a pending control word with bit 0 equal to 0 is committed. Committing a word with bit 0 equal to 1 leaves it unchanged, and writing bit 0 as 1 never sets it.
- R9: ctl_rdata has bits 11:7 and bit 1 at zero, bits 6:2 from the active configuration and bit 0 from the shutdown bit. Written values in data bits 11:7 and bit 1 have no effect.
- R10: A clearing commit while the synchronised over_temp is still high leaves the shutdown bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | One-cycle pulse per completed write frame |
| wr_addr | input | 3 | Frame address; 7 selects the control register |
| wr_data | input | 12 | Frame data field |
| over_temp | input | 1 | Raw over-temperature comparator flag |
| ch_en | output | 4 | Per-channel power-up enables, channel A at bit 0 |
| hiz_sel | output | 1 | Powered-down output mode: 1 high impedance, 0 resistor to ground |
| pwr_down | output | 1 | Whole stage powered down |
| alarm_n | output | 1 | Active-low thermal alarm |
| ctl_rdata | output | 12 | Readback value of the control register |

## Verification
Configuration results are registered in the edge that accepts the committing write frame. They are visible at the falling edge that ends that frame's strobe cycle, and the bench compares them there. It also compares at the same point after the control write itself, to show that nothing moved yet. The alarm path is three edges deep, so the bench samples at the falling edges after the first, second and third rising edge following over_temp. It expects the old value twice and the new value once. The sweep covers every enable and mode combination and commits through every address.

// File: rtl/thermctl_pkg.sv
package thermctl_pkg;
  localparam int CH_N    = 4;
  localparam int DATA_W  = 12;
  localparam int ADDR_W  = 3;
  localparam int TH_BIT  = 0;
  localparam int RSV_BIT = 1;
  localparam int EN_LSB  = 2;
  localparam int TRI_BIT = EN_LSB + CH_N;

  typedef struct packed {
    logic            tri_out;
    logic [CH_N-1:0] pwr_up;
  } ctl_cfg_t;
endpackage

// File: rtl/thermctl_sync.sv
module thermctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/thermctl_stage.sv
module thermctl_stage
  import thermctl_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTL_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_cfg_t          act_cfg,
  output logic              commit,
  output logic              commit_th
);
  ctl_cfg_t pend_cfg_q, pend_cfg_d;
  ctl_cfg_t act_cfg_q, act_cfg_d;
  logic     pend_th_q, pend_th_d;
  logic     pend_vld_q, pend_vld_d;
  logic     pend_ld;
  ctl_cfg_t wr_cfg;
  logic     unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-1:TRI_BIT+1], wr_data[RSV_BIT]};

  always_comb begin
    wr_cfg.tri_out = wr_data[TRI_BIT];
    wr_cfg.pwr_up  = wr_data[EN_LSB +: CH_N];
  end

  always_comb begin
    pend_ld    = wr_stb && (wr_addr == CTL_ADDR);
    commit     = wr_stb && pend_vld_q;
    act_cfg_d  = commit  ? pend_cfg_q : act_cfg_q;
    pend_cfg_d = pend_ld ? wr_cfg : pend_cfg_q;
    pend_th_d  = pend_ld ? wr_data[TH_BIT] : pend_th_q;
    pend_vld_d = pend_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cfg_q <= '0;
      pend_th_q  <= 1'b0;
      pend_vld_q <= 1'b0;
      act_cfg_q  <= '0;
    end else if (wr_stb) begin
      pend_cfg_q <= pend_cfg_d;
      pend_th_q  <= pend_th_d;
      pend_vld_q <= pend_vld_d;
      act_cfg_q  <= act_cfg_d;
    end
  end

  assign act_cfg   = act_cfg_q;
  assign commit_th = pend_th_q;
endmodule

// File: rtl/thermctl_latch.sv
module thermctl_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic commit,
  input  logic commit_th,
  output logic flag
);
  logic flag_q, flag_d, flag_en, clr_req;

  always_comb begin
    clr_req = commit && !commit_th;
    flag_en = hot || clr_req;
    flag_d  = hot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/thermctl_outmap.sv
module thermctl_outmap
  import thermctl_pkg::*;
(
  input  ctl_cfg_t          cfg,
  input  logic              flag,
  output logic [CH_N-1:0]   ch_en,
  output logic              hiz_sel,
  output logic              pwr_down,
  output logic              alarm_n,
  output logic [DATA_W-1:0] rd_word
);
  genvar gi;
  generate
    for (gi = 0; gi < CH_N; gi++) begin : g_ch
      assign ch_en[gi] = cfg.pwr_up[gi] && !flag;
    end
  endgenerate

  always_comb begin
    hiz_sel  = cfg.tri_out;
    pwr_down = flag || (cfg.pwr_up == '0);
    alarm_n  = !flag;
    rd_word                    = '0;
    rd_word[TH_BIT]            = flag;
    rd_word[EN_LSB +: CH_N]    = cfg.pwr_up;
    rd_word[TRI_BIT]           = cfg.tri_out;
  end
endmodule

// File: rtl/thermctl_top.sv
module thermctl_top
  import thermctl_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              over_temp,
  output logic [CH_N-1:0]   ch_en,
  output logic              hiz_sel,
  output logic              pwr_down,
  output logic              alarm_n,
  output logic [DATA_W-1:0] ctl_rdata
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       hot;
  logic       commit, commit_th, flag;
  ctl_cfg_t   act_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  thermctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(over_temp), .q(hot)
  );

  thermctl_stage #(.CTL_ADDR(CTL_ADDR)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .act_cfg(act_cfg), .commit(commit), .commit_th(commit_th)
  );

  thermctl_latch u_latch (
    .clk(clk), .rst_n(rst_int_n), .hot(hot), .commit(commit),
    .commit_th(commit_th), .flag(flag)
  );

  thermctl_outmap u_out (
    .cfg(act_cfg), .flag(flag), .ch_en(ch_en), .hiz_sel(hiz_sel),
    .pwr_down(pwr_down), .alarm_n(alarm_n), .rd_word(ctl_rdata)
  );
endmodule

// File: rtl/thermctl_chk.sv
module thermctl_chk
  import thermctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [CH_N-1:0]   ch_en,
  input logic              pwr_down,
  input logic              alarm_n,
  input logic [DATA_W-1:0] ctl_rdata
);
  AST_SHDN_GATES_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> (ch_en == '0 && pwr_down)); // R7
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_n && !wr_stb) |=> !alarm_n); // R6
  AST_CFG_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(ctl_rdata[TRI_BIT:EN_LSB])); // R2
  AST_EN_NOT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en != '0) |-> !pwr_down); // R5
  AST_RD_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[DATA_W-1:TRI_BIT+1] == '0) && !ctl_rdata[RSV_BIT]); // R9
  AST_FLAG_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[TH_BIT] == !alarm_n); // R6
endmodule

bind thermctl_top thermctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .ch_en(ch_en),
  .pwr_down(pwr_down), .alarm_n(alarm_n), .ctl_rdata(ctl_rdata)
);

// File: tb/tb_thermctl_top.sv
module tb_thermctl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [2:0]  wr_addr;
  logic [11:0] wr_data;
  logic        over_temp;
  logic [3:0]  ch_en;
  logic        hiz_sel, pwr_down, alarm_n;
  logic [11:0] ctl_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [3:0] m_en;
  logic       m_hiz, m_flag, m_pvld, m_phiz, m_pth, m_hot;
  logic [3:0] m_pen;

  always #2.5 clk = ~clk;

  thermctl_top dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .over_temp(over_temp), .ch_en(ch_en),
    .hiz_sel(hiz_sel), .pwr_down(pwr_down), .alarm_n(alarm_n),
    .ctl_rdata(ctl_rdata)
  );

  task automatic chk(input string rq);
    logic [11:0] e_rd;
    logic [3:0]  e_en;
    logic        e_pd;
    e_rd = {5'b0, m_hiz, m_en, 1'b0, m_flag};
    e_en = m_flag ? 4'b0 : m_en;
    e_pd = m_flag || (m_en == 4'b0);
    n_vec++;
    if (ctl_rdata !== e_rd || ch_en !== e_en || hiz_sel !== m_hiz ||
        pwr_down !== e_pd || alarm_n !== !m_flag) begin
      n_bad++;
      $display("FAIL %s: rd=%h en=%b hiz=%b pd=%b al=%b exp rd=%h en=%b hiz=%b pd=%b al=%b",
               rq, ctl_rdata, ch_en, hiz_sel, pwr_down, alarm_n,
               e_rd, e_en, m_hiz, e_pd, !m_flag);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [11:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    if (m_pvld) begin
      m_en  = m_pen;
      m_hiz = m_phiz;
      if (!m_pth && !m_hot) m_flag = 1'b0;
    end
    if (a == 3'd7) begin
      m_pvld = 1'b1; m_pen = d[5:2]; m_phiz = d[6]; m_pth = d[0];
    end else m_pvld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_hiz = 0; m_flag = 0; m_pvld = 0; m_phiz = 0; m_pth = 0;
    m_hot = 0; m_pen = 0;
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0; over_temp = 1'b0;
    idle(3);
    chk("R1 in reset");
    rst_n = 1'b1;
    idle(4);
    chk("R1 after release");

    // R3: frames with nothing pending change nothing
    do_write(3'd1, 12'hFFF); chk("R3 no pending");
    do_write(3'd5, 12'h07C); chk("R3 no pending");

    // Sweep all mode/enable words, committing through every address
    for (int v = 0; v < 64; v++) begin
      logic [11:0] d;
      d = {5'(v * 11), v[4:0], v[5], 1'b0};
      do_write(3'd7, d);
      chk("R2 held pending");
      do_write(3'(v % 8), {v[5:0], ~v[5:0]});
      chk("R3 R4 R5 R9 commit");
    end
    do_write(3'd0, 12'h000); chk("R3 flush");

    // Enable all channels, high-impedance mode
    do_write(3'd7, 12'h07C); do_write(3'd0, 12'h0); chk("R4 all on");

    // R8: C0 written as 1 never sets the flag
    do_write(3'd7, 12'h07D); do_write(3'd2, 12'h0); chk("R8 no set by write");

    // R6: alarm latency and stickiness
    over_temp = 1'b1;
    idle(1); chk("R6 latency edge1");
    idle(1); chk("R6 latency edge2");
    idle(1); m_flag = 1'b1; m_hot = 1'b1; chk("R6 R7 latency edge3");
    idle(5);
    over_temp = 1'b0; idle(4); m_hot = 1'b0;
    chk("R6 sticky after cool");

    // R10: clear attempt while still hot
    over_temp = 1'b1; idle(4); m_hot = 1'b1;
    do_write(3'd7, 12'h01C); do_write(3'd0, 12'h0);
    chk("R10 hot blocks clear");
    over_temp = 1'b0; idle(4); m_hot = 1'b0;
    chk("R7 enables stored, outputs off");

    // R8: commit with C0=1 keeps flag; C0=0 clears it
    do_write(3'd7, 12'h029); do_write(3'd4, 12'h0); chk("R8 C0=1 keeps");
    do_write(3'd7, 12'h030); chk("R8 pending clear not yet");
    do_write(3'd3, 12'h0);   chk("R8 clear on commit");
    idle(3); chk("R8 stays clear");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule